// File: doc/BRIEF.md
# Flow-Control Pause Frame Transmitter

This block builds MAC control frames for link-level pause and for eight-class priority pause, and merges them into a byte-wide transmit stream in front of user traffic. Two request sources drive it. A single link-level request bit produces frames that carry one 16-bit quanta value. A vector of eight class request bits produces frames that carry a class-enable field and eight per-class quanta. Every frame starts with a header taken from configuration inputs: destination address, source address, ethertype and opcode. All multi-byte fields go out most significant byte first. Frame check sequence, padding to the minimum length and line encoding are left to the logic downstream.

A frame is scheduled when a request changes state, when a held request's refresh timer runs out, or when a resend pulse arrives. Releasing a request produces a frame whose quanta are zero. Refresh timers count in pause-quanta units. One quanta is 512 bit times, which is `QUANTA_CYCLES` clocks of the byte-wide path. A four-state arbiter (`ST_IDLE`, `ST_USER`, `ST_LFC`, `ST_PFC`) picks work only at frame boundaries. From `ST_IDLE` it goes to `ST_LFC` if a link-level frame is pending, otherwise to `ST_PFC` if a class frame is pending, otherwise to `ST_USER` if user data is offered. `ST_USER` returns to `ST_IDLE` on the accepted last user byte. `ST_LFC` and `ST_PFC` return to `ST_IDLE` once their last byte is accepted.

Top module: `pause_frame_tx`

## Requirements
- R1: A link-level frame is 18 bytes: destination (6), source (6), ethertype (2), link opcode (2), quanta (2), each field most significant byte first. Its quanta is `cfg_lfc_quanta` when the request is held and 0 when it is released. `out_tlast` marks byte 17.
- R2: A class frame is 34 bytes: destination (6), source (6), ethertype (2), class opcode (2), enable field (2), then the quanta of class 0 up to class 7 (2 bytes each), all most significant byte first. The enable field has high byte 0 and low byte equal to the current request vector OR the previously sent vector. A class's quanta is its slice `cfg_pfc_quanta[16*i+:16]` when requested, else 0.
- R3: Each change of `lfc_req` produces exactly one link-level frame. Holding and releasing the request twice produces 4 frames.
- R4: Each change of the `pfc_req` vector produces exactly one class frame. Stepping it 0x01, 0x03, … 0xFF and then 0x00 produces 9 frames.
- R5: On each frame, the refresh timer of every source is loaded from its refresh setting. The timer decrements once per quanta tick, which comes every `QUANTA_CYCLES` clocks. While a request stays held and its timer is 0, a new frame is scheduled.
- R6: A one-cycle resend pulse schedules one extra frame that carries the current request state.
- R7: A user frame that has started is passed through unbroken up to its last byte. `in_tready` is high only while a user frame is being passed, and then it equals `out_tready`.
- R8: When both kinds are pending at a frame boundary, the link-level frame goes first, and both go before user data.
- R9: While `cfg_lfc_en` or `cfg_pfc_en` is low, no frame of that kind is sent, whatever its requests do.
- R10: While `out_tready` is low during a control frame, `out_tvalid` stays high and `out_tdata` holds its value.
- R11: During reset and in the first cycle after it, `out_tvalid` and `in_tready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dst | input | 48 | Destination address of control frames |
| cfg_src | input | 48 | Source address of control frames |
| cfg_etype | input | 16 | Ethertype of control frames |
| cfg_lfc_opcode | input | 16 | Opcode of link-level frames |
| cfg_lfc_quanta | input | 16 | Quanta sent while the link request is held |
| cfg_lfc_refresh | input | 16 | Link refresh interval in quanta |
| cfg_lfc_en | input | 1 | Enables link-level frames |
| cfg_pfc_opcode | input | 16 | Opcode of class frames |
| cfg_pfc_quanta | input | 128 | Per-class quanta, class i at bits 16*i+15:16*i |
| cfg_pfc_refresh | input | 128 | Per-class refresh intervals, same layout |
| cfg_pfc_en | input | 1 | Enables class frames |
| lfc_req | input | 1 | Link-level pause request |
| lfc_resend | input | 1 | Pulse: resend link-level state |
| pfc_req | input | 8 | Per-class pause requests |
| pfc_resend | input | 1 | Pulse: resend class state |
| in_tdata | input | 8 | User stream data |
| in_tvalid | input | 1 | User stream valid |
| in_tlast | input | 1 | User stream last byte |
| in_tready | output | 1 | User stream ready |
| out_tdata | output | 8 | Merged stream data |
| out_tvalid | output | 1 | Merged stream valid |
| out_tlast | output | 1 | Merged stream last byte |
| out_tready | input | 1 | Merged stream ready from downstream |

## Verification
The bench goes after the cases where a request changes while the arbiter is busy. It raises a pause request in the middle of a user frame: a design that preempted would cut the user frame short and splice control bytes into it. It raises both kinds of request in the same cycle: an arbiter with the wrong priority would send the class frame first. It shortens the refresh interval so that the timer runs out while a frame is still being sent: a timer that was not reloaded at launch, or that ignored the hold condition, would send too many frames or too few. It also checks the release frames, whose quanta must be zero and whose class-enable field must still name the classes being released. It checks that toggling requests while a kind is disabled sends nothing.

// File: rtl/pause_tx_pkg.sv
package pause_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_USER = 2'd1,
        ST_LFC  = 2'd2,
        ST_PFC  = 2'd3
    } arb_state_e;

    // header: destination, source, ethertype, opcode
    localparam int MAC_BYTES = 6;
    localparam int HDR_BYTES = 2 * MAC_BYTES + 4;
    localparam int QW        = 16;

endpackage

// File: rtl/pause_quanta_tick.sv
module pause_quanta_tick #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pause_lfc_engine.sv
module pause_lfc_engine #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          req,
    input  logic          resend,
    input  logic          tick,
    input  logic          take,
    input  logic [QW-1:0] cfg_quanta,
    input  logic [QW-1:0] cfg_refresh,
    output logic          pending,
    output logic [QW-1:0] snap_quanta
);
    logic          sent_q;
    logic [QW-1:0] tmr_q;
    logic          resend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q      <= 1'b0;
            tmr_q       <= '0;
            snap_quanta <= '0;
        end else if (take) begin
            sent_q      <= req;
            tmr_q       <= cfg_refresh;
            snap_quanta <= req ? cfg_quanta : '0;
        end else if (tick && (tmr_q != '0)) begin
            tmr_q <= tmr_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resend_q <= 1'b0;
        end else begin
            resend_q <= (resend_q & ~take) | resend;
        end
    end

    always_comb begin
        pending = en & ((req ^ sent_q) |
                        (req & sent_q & (tmr_q == '0)) |
                        resend_q);
    end
endmodule

// File: rtl/pause_pfc_engine.sv
module pause_pfc_engine #(
    parameter int CLASSES = 8,
    parameter int QW      = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic [CLASSES-1:0]    req,
    input  logic                  resend,
    input  logic                  tick,
    input  logic                  take,
    input  logic [CLASSES*QW-1:0] cfg_quanta,
    input  logic [CLASSES*QW-1:0] cfg_refresh,
    output logic                  pending,
    output logic [CLASSES-1:0]    snap_enable,
    output logic [CLASSES*QW-1:0] snap_quanta
);
    logic [CLASSES-1:0] sent_q;
    logic [CLASSES-1:0] expired;
    logic               resend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sent_q      <= '0;
            snap_enable <= '0;
        end else if (take) begin
            sent_q      <= req;
            snap_enable <= req | sent_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resend_q <= 1'b0;
        end else begin
            resend_q <= (resend_q & ~take) | resend;
        end
    end

    for (genvar g = 0; g < CLASSES; g++) begin : g_class
        logic [QW-1:0] tmr_q;
        logic [QW-1:0] snap_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                tmr_q  <= '0;
                snap_q <= '0;
            end else if (take) begin
                tmr_q  <= cfg_refresh[g*QW +: QW];
                snap_q <= req[g] ? cfg_quanta[g*QW +: QW] : '0;
            end else if (tick && (tmr_q != '0)) begin
                tmr_q <= tmr_q - 1'b1;
            end
        end

        assign expired[g]               = req[g] & sent_q[g] & (tmr_q == '0);
        assign snap_quanta[g*QW +: QW]  = snap_q;
    end

    always_comb begin
        pending = en & ((req != sent_q) | (|expired) | resend_q);
    end
endmodule

// File: rtl/pause_byte_sel.sv
module pause_byte_sel
    import pause_tx_pkg::*;
#(
    parameter int CLASSES = 8,
    parameter int IDX_W   = 6
) (
    input  logic                  is_class,
    input  logic [IDX_W-1:0]      idx,
    input  logic [47:0]           cfg_dst,
    input  logic [47:0]           cfg_src,
    input  logic [15:0]           cfg_etype,
    input  logic [15:0]           lfc_opcode,
    input  logic [15:0]           pfc_opcode,
    input  logic [QW-1:0]         lfc_quanta,
    input  logic [CLASSES-1:0]    pfc_enable,
    input  logic [CLASSES*QW-1:0] pfc_quanta,
    output logic [7:0]            byte_o
);
    logic [15:0] opcode;
    logic [15:0] en_field;
    logic [15:0] cls_q;
    int          pos;
    int          pl;
    int          k;

    always_comb begin
        opcode   = is_class ? pfc_opcode : lfc_opcode;
        en_field = 16'(pfc_enable);
        pos      = int'(idx);
        pl       = pos - HDR_BYTES;
        k        = (pl >= 2) ? (pl - 2) : 0;
        cls_q    = 16'(pfc_quanta >> (QW * (k / 2)));
        byte_o   = 8'h00;
        if (pos < MAC_BYTES) begin
            byte_o = 8'(cfg_dst >> (8 * (MAC_BYTES - 1 - pos)));
        end else if (pos < 2 * MAC_BYTES) begin
            byte_o = 8'(cfg_src >> (8 * (2 * MAC_BYTES - 1 - pos)));
        end else if (pos == 2 * MAC_BYTES) begin
            byte_o = cfg_etype[15:8];
        end else if (pos == 2 * MAC_BYTES + 1) begin
            byte_o = cfg_etype[7:0];
        end else if (pos == 2 * MAC_BYTES + 2) begin
            byte_o = opcode[15:8];
        end else if (pos == 2 * MAC_BYTES + 3) begin
            byte_o = opcode[7:0];
        end else if (!is_class) begin
            byte_o = (pl == 0) ? lfc_quanta[15:8] : lfc_quanta[7:0];
        end else if (pl < 2) begin
            byte_o = (pl == 0) ? en_field[15:8] : en_field[7:0];
        end else begin
            byte_o = (k % 2 == 0) ? cls_q[15:8] : cls_q[7:0];
        end
    end
endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
    import pause_tx_pkg::*;
#(
    parameter int QUANTA_CYCLES = 64,
    parameter int CLASSES       = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [47:0]           cfg_dst,
    input  logic [47:0]           cfg_src,
    input  logic [15:0]           cfg_etype,
    input  logic [15:0]           cfg_lfc_opcode,
    input  logic [15:0]           cfg_lfc_quanta,
    input  logic [15:0]           cfg_lfc_refresh,
    input  logic                  cfg_lfc_en,
    input  logic [15:0]           cfg_pfc_opcode,
    input  logic [CLASSES*16-1:0] cfg_pfc_quanta,
    input  logic [CLASSES*16-1:0] cfg_pfc_refresh,
    input  logic                  cfg_pfc_en,
    input  logic                  lfc_req,
    input  logic                  lfc_resend,
    input  logic [CLASSES-1:0]    pfc_req,
    input  logic                  pfc_resend,
    input  logic [7:0]            in_tdata,
    input  logic                  in_tvalid,
    input  logic                  in_tlast,
    output logic                  in_tready,
    output logic [7:0]            out_tdata,
    output logic                  out_tvalid,
    output logic                  out_tlast,
    input  logic                  out_tready
);
    localparam int LFC_LEN = HDR_BYTES + 2;
    localparam int PFC_LEN = HDR_BYTES + 2 + 2 * CLASSES;
    localparam int IDX_W   = $clog2(PFC_LEN);

    arb_state_e               state, state_d;
    logic [IDX_W-1:0]         idx_q, idx_d;
    logic                     tick;
    logic                     lfc_pend, pfc_pend;
    logic                     lfc_take, pfc_take;
    logic [QW-1:0]            lfc_snap_q;
    logic [CLASSES-1:0]       pfc_snap_en;
    logic [CLASSES*QW-1:0]    pfc_snap_q;
    logic [7:0]               ctrl_byte;

    pause_quanta_tick #(.CYCLES(QUANTA_CYCLES)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    pause_lfc_engine #(.QW(QW)) u_lfc (
        .clk         (clk),
        .rst         (rst),
        .en          (cfg_lfc_en),
        .req         (lfc_req),
        .resend      (lfc_resend),
        .tick        (tick),
        .take        (lfc_take),
        .cfg_quanta  (cfg_lfc_quanta),
        .cfg_refresh (cfg_lfc_refresh),
        .pending     (lfc_pend),
        .snap_quanta (lfc_snap_q)
    );

    pause_pfc_engine #(.CLASSES(CLASSES), .QW(QW)) u_pfc (
        .clk         (clk),
        .rst         (rst),
        .en          (cfg_pfc_en),
        .req         (pfc_req),
        .resend      (pfc_resend),
        .tick        (tick),
        .take        (pfc_take),
        .cfg_quanta  (cfg_pfc_quanta),
        .cfg_refresh (cfg_pfc_refresh),
        .pending     (pfc_pend),
        .snap_enable (pfc_snap_en),
        .snap_quanta (pfc_snap_q)
    );

    pause_byte_sel #(.CLASSES(CLASSES), .IDX_W(IDX_W)) u_sel (
        .is_class   (state == ST_PFC),
        .idx        (idx_q),
        .cfg_dst    (cfg_dst),
        .cfg_src    (cfg_src),
        .cfg_etype  (cfg_etype),
        .lfc_opcode (cfg_lfc_opcode),
        .pfc_opcode (cfg_pfc_opcode),
        .lfc_quanta (lfc_snap_q),
        .pfc_enable (pfc_snap_en),
        .pfc_quanta (pfc_snap_q),
        .byte_o     (ctrl_byte)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx_q <= '0;
        end else begin
            state <= state_d;
            idx_q <= idx_d;
        end
    end

    // next state and launch strobes
    always_comb begin
        state_d  = state;
        idx_d    = idx_q;
        lfc_take = 1'b0;
        pfc_take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (lfc_pend) begin
                    state_d  = ST_LFC;
                    idx_d    = '0;
                    lfc_take = 1'b1;
                end else if (pfc_pend) begin
                    state_d  = ST_PFC;
                    idx_d    = '0;
                    pfc_take = 1'b1;
                end else if (in_tvalid) begin
                    state_d = ST_USER;
                end
            end
            ST_USER: begin
                if (in_tvalid && out_tready && in_tlast) begin
                    state_d = ST_IDLE;
                end
            end
            ST_LFC: begin
                if (out_tready) begin
                    if (idx_q == IDX_W'(LFC_LEN - 1)) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            ST_PFC: begin
                if (out_tready) begin
                    if (idx_q == IDX_W'(PFC_LEN - 1)) begin
                        state_d = ST_IDLE;
                        idx_d   = '0;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        out_tvalid = 1'b0;
        out_tdata  = 8'h00;
        out_tlast  = 1'b0;
        in_tready  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                out_tvalid = 1'b0;
            end
            ST_USER: begin
                out_tvalid = in_tvalid;
                out_tdata  = in_tdata;
                out_tlast  = in_tlast;
                in_tready  = out_tready;
            end
            ST_LFC: begin
                out_tvalid = 1'b1;
                out_tdata  = ctrl_byte;
                out_tlast  = (idx_q == IDX_W'(LFC_LEN - 1));
            end
            ST_PFC: begin
                out_tvalid = 1'b1;
                out_tdata  = ctrl_byte;
                out_tlast  = (idx_q == IDX_W'(PFC_LEN - 1));
            end
        endcase
    end
endmodule

// File: rtl/pause_frame_tx_chk.sv
module pause_frame_tx_chk
    import pause_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input arb_state_e state,
    input logic       in_tvalid,
    input logic       in_tlast,
    input logic       in_tready,
    input logic       out_tvalid,
    input logic       out_tready,
    input logic [7:0] out_tdata,
    input logic       lfc_take,
    input logic       pfc_take
);
    a_r11_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_tvalid && !in_tready));

    a_r7_user_unbroken: assert property (@(posedge clk) disable iff (rst)
        (state == ST_USER && !(in_tvalid && out_tready && in_tlast)) |=> (state == ST_USER));

    a_r7_ready_only_user: assert property (@(posedge clk) disable iff (rst)
        in_tready |-> (state == ST_USER));

    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_tvalid && !out_tready && (state == ST_LFC || state == ST_PFC))
        |=> (out_tvalid && $stable(out_tdata)));

    a_r8_one_launch: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lfc_take, pfc_take}));

    a_r8_launch_from_idle: assert property (@(posedge clk) disable iff (rst)
        (lfc_take || pfc_take) |-> (state == ST_IDLE));
endmodule

bind pause_frame_tx pause_frame_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .state      (state),
    .in_tvalid  (in_tvalid),
    .in_tlast   (in_tlast),
    .in_tready  (in_tready),
    .out_tvalid (out_tvalid),
    .out_tready (out_tready),
    .out_tdata  (out_tdata),
    .lfc_take   (lfc_take),
    .pfc_take   (pfc_take)
);

// File: tb/pause_frame_tx_test.sv
module pause_frame_tx_test;
    localparam int QC = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [47:0]  cfg_dst = 48'h0180C2000001;
    logic [47:0]  cfg_src = 48'h5A5152535455;
    logic [15:0]  cfg_etype = 16'h8808;
    logic [15:0]  cfg_lfc_opcode = 16'h0001;
    logic [15:0]  cfg_lfc_quanta = 16'hFFFF;
    logic [15:0]  cfg_lfc_refresh = 16'hFFFF;
    logic         cfg_lfc_en = 1'b1;
    logic [15:0]  cfg_pfc_opcode = 16'h0101;
    logic [127:0] cfg_pfc_quanta;
    logic [127:0] cfg_pfc_refresh;
    logic         cfg_pfc_en = 1'b1;
    logic         lfc_req = 1'b0, lfc_resend = 1'b0, pfc_resend = 1'b0;
    logic [7:0]   pfc_req = 8'h00;
    logic [7:0]   in_tdata = 8'h00;
    logic         in_tvalid = 1'b0, in_tlast = 1'b0;
    logic         in_tready;
    logic [7:0]   out_tdata;
    logic         out_tvalid, out_tlast;
    logic         out_tready = 1'b1;

    pause_frame_tx #(.QUANTA_CYCLES(QC), .CLASSES(8)) uut (
        .clk(clk), .rst(rst), .cfg_dst(cfg_dst), .cfg_src(cfg_src),
        .cfg_etype(cfg_etype), .cfg_lfc_opcode(cfg_lfc_opcode),
        .cfg_lfc_quanta(cfg_lfc_quanta), .cfg_lfc_refresh(cfg_lfc_refresh),
        .cfg_lfc_en(cfg_lfc_en), .cfg_pfc_opcode(cfg_pfc_opcode),
        .cfg_pfc_quanta(cfg_pfc_quanta), .cfg_pfc_refresh(cfg_pfc_refresh),
        .cfg_pfc_en(cfg_pfc_en), .lfc_req(lfc_req), .lfc_resend(lfc_resend),
        .pfc_req(pfc_req), .pfc_resend(pfc_resend), .in_tdata(in_tdata),
        .in_tvalid(in_tvalid), .in_tlast(in_tlast), .in_tready(in_tready),
        .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tlast(out_tlast),
        .out_tready(out_tready)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 1'b0, started = 1'b0, stall_en = 1'b0;
    int cyc = 0;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int        m_st = 0, m_idx = 0, m_cnt = 0;
    logic [7:0] m_frame[$];
    bit        m_lsent = 0, m_lres = 0, m_pres = 0;
    int        m_ltmr = 0;
    bit [7:0]  m_psent = 0;
    int        m_ptmr[8];
    int        m_lfc_launch = 0, m_pfc_launch = 0;
    bit        mt, mlp, mpp, mlt, mpt, mexp;
    bit [7:0]  men;

    task automatic push16(logic [15:0] v);
        m_frame.push_back(v[15:8]);
        m_frame.push_back(v[7:0]);
    endtask

    task automatic push_hdr(logic [15:0] op);
        m_frame.delete();
        for (int i = 5; i >= 0; i--) m_frame.push_back(cfg_dst[8*i +: 8]);
        for (int i = 5; i >= 0; i--) m_frame.push_back(cfg_src[8*i +: 8]);
        push16(cfg_etype);
        push16(op);
    endtask

    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            m_st = 0; m_idx = 0; m_cnt = 0; m_lsent = 0; m_lres = 0; m_pres = 0;
            m_ltmr = 0; m_psent = 0;
            for (int i = 0; i < 8; i++) m_ptmr[i] = 0;
        end else begin
            mt = (m_cnt == QC - 1);
            mlp = cfg_lfc_en && ((lfc_req != m_lsent) || (lfc_req && m_lsent && m_ltmr == 0) || m_lres);
            mexp = 0;
            for (int i = 0; i < 8; i++) if (pfc_req[i] && m_psent[i] && m_ptmr[i] == 0) mexp = 1;
            mpp = cfg_pfc_en && ((pfc_req != m_psent) || mexp || m_pres);
            mlt = 0; mpt = 0;
            case (m_st)
                0: if (mlp) begin mlt = 1; m_st = 2; m_idx = 0; end
                   else if (mpp) begin mpt = 1; m_st = 3; m_idx = 0; end
                   else if (in_tvalid) m_st = 1;
                1: if (in_tvalid && out_tready && in_tlast) m_st = 0;
                default: if (out_tready) begin
                    if (m_idx == m_frame.size() - 1) begin m_st = 0; m_idx = 0; end
                    else m_idx++;
                end
            endcase
            if (mlt) begin
                push_hdr(cfg_lfc_opcode);
                push16(lfc_req ? cfg_lfc_quanta : 16'h0);
                m_lsent = lfc_req; m_ltmr = cfg_lfc_refresh; m_lfc_launch++;
            end else if (mt && m_ltmr > 0) m_ltmr--;
            m_lres = (m_lres && !mlt) || lfc_resend;
            if (mpt) begin
                men = pfc_req | m_psent;
                push_hdr(cfg_pfc_opcode);
                push16({8'h00, men});
                for (int i = 0; i < 8; i++) push16(pfc_req[i] ? cfg_pfc_quanta[16*i +: 16] : 16'h0);
                m_psent = pfc_req; m_pfc_launch++;
                for (int i = 0; i < 8; i++) m_ptmr[i] = cfg_pfc_refresh[16*i +: 16];
            end else if (mt) begin
                for (int i = 0; i < 8; i++) if (m_ptmr[i] > 0) m_ptmr[i]--;
            end
            m_pres = (m_pres && !mpt) || pfc_resend;
            m_cnt = mt ? 0 : m_cnt + 1;
        end
    end

    // ---------------- per-cycle comparison and frame tracking ----------------
    int lfc_seen = 0, pfc_seen = 0, out_pos = 0;
    int kinds[$];          // 0 user, 1 link-level, 2 class
    int user_lens[$];
    logic [15:0] lfc_q_seen[$];
    logic [7:0]  cur[$];
    bit ev, el, er;
    logic [7:0] ed;
    string tag;

    always @(negedge clk) begin
        cyc++;
        out_tready = !stall_en || (cyc % 5 != 2);
        #1;
        if (started) begin
            ev = 0; ed = 8'h00; el = 0; er = 0;
            case (m_st)
                1: begin ev = in_tvalid; ed = in_tdata; el = in_tlast; er = out_tready; end
                2, 3: begin ev = 1; ed = m_frame[m_idx]; el = (m_idx == m_frame.size() - 1); end
                default: ;
            endcase
            case (m_st)
                0: tag = "R11";
                1: tag = "R7";
                2: tag = out_tready ? "R1" : "R10";
                default: tag = out_tready ? "R2" : "R10";
            endcase
            check((out_tvalid === ev) && (in_tready === er) &&
                  (!ev || ((out_tdata === ed) && (out_tlast === el))),
                  tag, "ports {valid,ready,last,data}",
                  {out_tvalid, in_tready, out_tlast, out_tdata},
                  {ev, er, el, ed});
            if (!rst && out_tvalid && out_tready) begin
                cur.push_back(out_tdata);
                out_pos++;
                if (out_tlast) begin
                    if (out_pos == 18) begin
                        lfc_seen++; kinds.push_back(1);
                        lfc_q_seen.push_back({cur[16], cur[17]});
                    end else if (out_pos == 34) begin
                        pfc_seen++; kinds.push_back(2);
                    end else begin
                        kinds.push_back(0); user_lens.push_back(out_pos);
                    end
                    out_pos = 0; cur.delete();
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_user(int len, int base);
        bit hs;
        for (int b = 0; b < len; b++) begin
            in_tvalid = 1'b1; in_tdata = 8'(base + b); in_tlast = (b == len - 1);
            hs = 1'b0;
            while (!hs) begin
                #1;
                hs = in_tready;
                @(negedge clk);
            end
        end
        in_tvalid = 1'b0; in_tlast = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    int b0, k0;

    initial begin
        for (int i = 0; i < 8; i++) begin
            cfg_pfc_quanta[16*i +: 16]  = 16'h1000 + 16'(i * 16'h111);
            cfg_pfc_refresh[16*i +: 16] = 16'hFFFF;
        end
        wait_cyc(4);
        #1;
        check(!out_tvalid && !in_tready, "R11", "outputs during reset",
              {out_tvalid, in_tready}, 0);
        @(negedge clk);
        rst = 1'b0;
        wait_cyc(2);

        // user traffic with back-pressure
        stall_en = 1'b1;
        send_user(7, 8'h10);
        send_user(12, 8'h40);
        wait_cyc(4);
        check(user_lens.size() == 2 && user_lens[1] == 12, "R7", "user frames passed",
              user_lens.size(), 2);

        // R3: hold/release twice
        repeat (2) begin
            lfc_req = 1'b1; wait_cyc(60);
            lfc_req = 1'b0; wait_cyc(60);
        end
        check(lfc_seen == 4, "R3", "link frames after two hold/release", lfc_seen, 4);
        check(lfc_q_seen[0] == 16'hFFFF && lfc_q_seen[1] == 16'h0, "R1", "hold then release quanta",
              {lfc_q_seen[0], lfc_q_seen[1]}, 32'hFFFF0000);

        // R4: step class vector
        for (int i = 0; i < 8; i++) begin
            pfc_req = 8'hFF >> (7 - i); wait_cyc(80);
        end
        pfc_req = 8'h00; wait_cyc(80);
        check(pfc_seen == 9, "R4", "class frames for stepped vector", pfc_seen, 9);
        check(m_pfc_launch == 9, "R2", "class frames scheduled", m_pfc_launch, 9);

        // R9: disabled link kind ignores requests
        b0 = lfc_seen;
        cfg_lfc_en = 1'b0;
        lfc_req = 1'b1; wait_cyc(40);
        lfc_req = 1'b0; wait_cyc(40);
        cfg_lfc_en = 1'b1; wait_cyc(10);
        check(lfc_seen == b0, "R9", "link frames while disabled", lfc_seen, b0);

        // R5: short refresh keeps re-sending
        b0 = lfc_seen;
        cfg_lfc_refresh = 16'd2;
        lfc_req = 1'b1; wait_cyc(150);
        lfc_req = 1'b0; wait_cyc(60);
        cfg_lfc_refresh = 16'hFFFF;
        check(lfc_seen - b0 >= 4, "R5", "refresh frames while held", lfc_seen - b0, 4);
        check(lfc_seen == m_lfc_launch, "R5", "refresh frame count", lfc_seen, m_lfc_launch);

        // R6: resend
        lfc_req = 1'b1; wait_cyc(40);
        b0 = lfc_seen;
        lfc_resend = 1'b1; wait_cyc(1); lfc_resend = 1'b0;
        wait_cyc(40);
        check(lfc_seen == b0 + 1, "R6", "one extra frame on resend", lfc_seen, b0 + 1);
        check(lfc_q_seen[lfc_q_seen.size()-1] == 16'hFFFF, "R6", "resend carries held quanta",
              lfc_q_seen[lfc_q_seen.size()-1], 16'hFFFF);
        lfc_req = 1'b0; wait_cyc(40);

        // R8: both pending in the same cycle
        k0 = kinds.size();
        lfc_req = 1'b1; pfc_req = 8'h05; wait_cyc(100);
        check(kinds.size() == k0 + 2 && kinds[k0] == 1 && kinds[k0+1] == 2, "R8",
              "link frame ahead of class frame", kinds[k0], 1);
        lfc_req = 1'b0; pfc_req = 8'h00; wait_cyc(100);

        // R7: request arrives mid user frame
        k0 = kinds.size();
        fork
            send_user(30, 8'h80);
            begin wait_cyc(5); lfc_req = 1'b1; end
        join
        wait_cyc(60);
        check(kinds.size() >= k0 + 2 && kinds[k0] == 0 && user_lens[user_lens.size()-1] == 30,
              "R7", "user frame completes before control frame", user_lens[user_lens.size()-1], 30);
        check(kinds[k0+1] == 1, "R7", "control frame after user frame", kinds[k0+1], 1);
        lfc_req = 1'b0; wait_cyc(60);
        stall_en = 1'b0; wait_cyc(5);

        check(lfc_seen == m_lfc_launch && pfc_seen == m_pfc_launch, "R3", "total frame counts",
              lfc_seen + pfc_seen, m_lfc_launch + m_pfc_launch);
        finish_run();
    end
endmodule